// File: doc/BRIEF.md
# Row-Hit-Aware Memory Request Scheduler

This block holds a small queue of pending memory requests and, every cycle, names the one that should go to the DRAM command logic next. Each queued request carries a bank, a row, a thread tag and a wait counter that starts when the request enters the queue. The block keeps one open-row record per bank. A request whose row matches the open row of its bank is a row hit.

A two-bit policy input picks the selection rule. In arrival-order mode the request that has waited longest wins and hits are ignored. In hit-first mode any row hit beats any non-hit, and age decides within each class. In fair mode the hit-first rule applies until some request has waited `STARVE_LIMIT` cycles or more. Once that happens, the longest-waiting such request wins outright. The selection is combinational over the stored queue, so a policy change shows on the outputs in the same cycle.

When the consumer raises `issue_ack` while `issue_valid` is high, the chosen entry leaves the queue at that clock edge. At the same edge the open-row record of its bank takes the issued row. DRAM timing and the data path are outside this block.

Top module: `req_sched`

## Requirements
- R1: After reset the queue is empty, `issue_valid` is low, `push_ready` is high, and every bank is closed, so no request counts as a row hit until a request to that bank has issued.
- R2: A push (`push_valid` and `push_ready` both high at a clock edge) stores the request in the lowest-numbered free slot. `push_ready` is low when all `DEPTH` slots are full, and a push attempted then is dropped and never issued.
- R3: `issue_valid` is high exactly when at least one slot holds a request. `issue_idx`, `issue_bank`, `issue_row` and `issue_thread` then describe the selected slot.
- R4: With `policy` = 0 (arrival order, and also for code 3), the request with the largest wait count is selected whether or not it hits. Equal wait counts go to the lower slot index.
- R5: With `policy` = 1 (hit-first), a row-hit request is selected over every non-hit. Within the chosen class the largest wait count wins, and a tie goes to the lower index.
- R6: With `policy` = 2 (fair), any request whose wait count is at least `STARVE_LIMIT` is preferred over all others, row hits included, and the oldest such request wins. With no such request the rule of R5 applies.
- R7: A request's wait count is 0 in the cycle after its push edge. It rises by one at each later clock edge and saturates at its maximum value.
- R8: On `issue_valid && issue_ack` at a clock edge, the selected slot becomes free and the open row of its bank becomes the issued row. A push at that same edge does not take the slot being freed.
- R9: The selection follows `policy` and the queue contents within the same cycle, with no register between them and the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| policy | input | 2 | Selection rule: 0 arrival order, 1 hit-first, 2 fair, 3 as 0 |
| push_valid | input | 1 | New request offered |
| push_bank | input | BANK_W | Bank of the new request |
| push_row | input | ROW_W | Row of the new request |
| push_thread | input | THREAD_W | Thread tag of the new request |
| push_ready | output | 1 | A free slot exists |
| issue_valid | output | 1 | A request is selected |
| issue_idx | output | IDX_W | Slot index of the selected request |
| issue_bank | output | BANK_W | Bank of the selected request |
| issue_row | output | ROW_W | Row of the selected request |
| issue_thread | output | THREAD_W | Thread tag of the selected request |
| issue_ack | input | 1 | Consumer takes the selected request |

## Verification
A push can land in the same clock edge that frees a slot through an acknowledged issue. The bench provokes this by raising `issue_ack` and `push_valid` together while three entries are queued and slot 0 is being issued. The push must go to slot 3 and not to the slot being freed. This is judged by draining the queue in arrival order and checking that the new request appears last, at index 3, with its own row. A second overlap comes from an issue that reopens a bank's row while other entries to that bank wait. The bench confirms that those entries become hits in the following cycle.

// File: rtl/req_sched_pkg.sv
package req_sched_pkg;
  typedef enum logic [1:0] {
    POL_FCFS   = 2'd0,
    POL_ROWHIT = 2'd1,
    POL_FAIR   = 2'd2,
    POL_RSVD   = 2'd3
  } policy_e;
endpackage

// File: rtl/sched_queue.sv
module sched_queue #(
  parameter int DEPTH    = 8,
  parameter int BANK_W   = 2,
  parameter int ROW_W    = 12,
  parameter int THREAD_W = 2,
  parameter int AGE_W    = 8,
  localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            push_en,
  input  logic [BANK_W-1:0]               push_bank,
  input  logic [ROW_W-1:0]                push_row,
  input  logic [THREAD_W-1:0]             push_thread,
  input  logic                            free_en,
  input  logic [IDX_W-1:0]                free_idx,
  output logic [DEPTH-1:0]                valid_o,
  output logic [DEPTH-1:0][BANK_W-1:0]    bank_o,
  output logic [DEPTH-1:0][ROW_W-1:0]     row_o,
  output logic [DEPTH-1:0][THREAD_W-1:0]  thread_o,
  output logic [DEPTH-1:0][AGE_W-1:0]     age_o,
  output logic                            full_o
);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  logic [DEPTH-1:0]               valid_q;
  logic [DEPTH-1:0][BANK_W-1:0]   bank_q;
  logic [DEPTH-1:0][ROW_W-1:0]    row_q;
  logic [DEPTH-1:0][THREAD_W-1:0] thread_q;
  logic [DEPTH-1:0][AGE_W-1:0]    age_q;
  logic [IDX_W-1:0]               slot;
  logic                           has_free;

  // lowest free slot
  always_comb begin
    slot     = '0;
    has_free = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!valid_q[i]) begin
        slot     = IDX_W'(i);
        has_free = 1'b1;
      end
    end
  end

  // payload storage, no reset needed
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (push_en && slot == IDX_W'(i)) begin
        bank_q[i]   <= push_bank;
        row_q[i]    <= push_row;
        thread_q[i] <= push_thread;
      end
    end
  end

  // occupancy and wait counters
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      age_q   <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (push_en && slot == IDX_W'(i)) begin
          valid_q[i] <= 1'b1;
          age_q[i]   <= '0;
        end else begin
          if (free_en && free_idx == IDX_W'(i)) valid_q[i] <= 1'b0;
          if (valid_q[i] && age_q[i] != AGE_MAX) age_q[i] <= age_q[i] + 1'b1;
        end
      end
    end
  end

  assign valid_o  = valid_q;
  assign bank_o   = bank_q;
  assign row_o    = row_q;
  assign thread_o = thread_q;
  assign age_o    = age_q;
  assign full_o   = !has_free;

  // R2
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (full_o && !free_en) |=> $stable(valid_q));

  // R8
  free_slot_chk: assert property (@(posedge clk) disable iff (rst)
    free_en |=> !valid_q[$past(free_idx)]);
endmodule

// File: rtl/open_row_table.sv
module open_row_table #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              upd_en,
  input  logic [BANK_W-1:0]                 upd_bank,
  input  logic [ROW_W-1:0]                  upd_row,
  output logic [NUM_BANKS-1:0]              open_o,
  output logic [NUM_BANKS-1:0][ROW_W-1:0]   row_o
);
  logic [NUM_BANKS-1:0]            open_q;
  logic [NUM_BANKS-1:0][ROW_W-1:0] row_q;

  always_ff @(posedge clk) begin
    if (upd_en) row_q[upd_bank] <= upd_row;
  end

  always_ff @(posedge clk) begin
    if (rst)         open_q <= '0;
    else if (upd_en) open_q[upd_bank] <= 1'b1;
  end

  assign open_o = open_q;
  assign row_o  = row_q;

  // R8
  row_update_chk: assert property (@(posedge clk) disable iff (rst)
    upd_en |=> (open_q[$past(upd_bank)] && row_q[$past(upd_bank)] == $past(upd_row)));
endmodule

// File: rtl/pick_arbiter.sv
module pick_arbiter
  import req_sched_pkg::*;
#(
  parameter int DEPTH        = 8,
  parameter int AGE_W        = 8,
  parameter int STARVE_LIMIT = 20,
  localparam int IDX_W       = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int KEY_W       = AGE_W + 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  policy_e                      policy,
  input  logic [DEPTH-1:0]             valid,
  input  logic [DEPTH-1:0]             hit,
  input  logic [DEPTH-1:0][AGE_W-1:0]  age,
  output logic                         sel_valid,
  output logic [IDX_W-1:0]             sel_idx
);
  logic             hit_mode;
  logic             fair_mode;
  logic [DEPTH-1:0] starve;
  logic [DEPTH-1:0][KEY_W-1:0] key;
  logic [KEY_W-1:0] best_key;

  assign hit_mode  = (policy == POL_ROWHIT) || (policy == POL_FAIR);
  assign fair_mode = (policy == POL_FAIR);

  for (genvar i = 0; i < DEPTH; i++) begin : g_key
    assign starve[i] = valid[i] && (int'(age[i]) >= STARVE_LIMIT);
    // starving entries rank above hits; hit bit masked when starving
    assign key[i] = {starve[i] && fair_mode,
                     hit[i] && hit_mode && !(starve[i] && fair_mode),
                     age[i]};
  end

  always_comb begin
    sel_valid = 1'b0;
    sel_idx   = '0;
    best_key  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (valid[i] && (!sel_valid || key[i] > best_key)) begin
        sel_valid = 1'b1;
        sel_idx   = IDX_W'(i);
        best_key  = key[i];
      end
    end
  end

  // R6
  starve_first_chk: assert property (@(posedge clk) disable iff (rst)
    (fair_mode && (|starve)) |-> (sel_valid && starve[sel_idx]));
endmodule

// File: rtl/req_sched.sv
module req_sched
  import req_sched_pkg::*;
#(
  parameter int DEPTH        = 8,
  parameter int NUM_BANKS    = 4,
  parameter int ROW_W        = 12,
  parameter int THREAD_W     = 2,
  parameter int AGE_W        = 8,
  parameter int STARVE_LIMIT = 20,
  localparam int IDX_W       = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int BANK_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          policy,
  input  logic                push_valid,
  input  logic [BANK_W-1:0]   push_bank,
  input  logic [ROW_W-1:0]    push_row,
  input  logic [THREAD_W-1:0] push_thread,
  output logic                push_ready,
  output logic                issue_valid,
  output logic [IDX_W-1:0]    issue_idx,
  output logic [BANK_W-1:0]   issue_bank,
  output logic [ROW_W-1:0]    issue_row,
  output logic [THREAD_W-1:0] issue_thread,
  input  logic                issue_ack
);
  policy_e                       pol;
  logic                          full;
  logic                          push_en;
  logic                          free_en;
  logic [DEPTH-1:0]              valid_vec;
  logic [DEPTH-1:0][BANK_W-1:0]  bank_vec;
  logic [DEPTH-1:0][ROW_W-1:0]   row_vec;
  logic [DEPTH-1:0][THREAD_W-1:0] thread_vec;
  logic [DEPTH-1:0][AGE_W-1:0]   age_vec;
  logic [DEPTH-1:0]              hit_vec;
  logic [NUM_BANKS-1:0]          bank_open;
  logic [NUM_BANKS-1:0][ROW_W-1:0] bank_row;

  assign pol        = policy_e'(policy);
  assign push_ready = !full;
  assign push_en    = push_valid && !full;
  assign free_en    = issue_valid && issue_ack;

  sched_queue #(
    .DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W),
    .THREAD_W(THREAD_W), .AGE_W(AGE_W)
  ) u_queue (
    .clk(clk), .rst(rst),
    .push_en(push_en), .push_bank(push_bank), .push_row(push_row),
    .push_thread(push_thread),
    .free_en(free_en), .free_idx(issue_idx),
    .valid_o(valid_vec), .bank_o(bank_vec), .row_o(row_vec),
    .thread_o(thread_vec), .age_o(age_vec), .full_o(full)
  );

  open_row_table #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_rows (
    .clk(clk), .rst(rst),
    .upd_en(free_en), .upd_bank(issue_bank), .upd_row(issue_row),
    .open_o(bank_open), .row_o(bank_row)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_hit
    assign hit_vec[i] = valid_vec[i] && bank_open[bank_vec[i]] &&
                        (bank_row[bank_vec[i]] == row_vec[i]);
  end

  pick_arbiter #(
    .DEPTH(DEPTH), .AGE_W(AGE_W), .STARVE_LIMIT(STARVE_LIMIT)
  ) u_pick (
    .clk(clk), .rst(rst), .policy(pol),
    .valid(valid_vec), .hit(hit_vec), .age(age_vec),
    .sel_valid(issue_valid), .sel_idx(issue_idx)
  );

  assign issue_bank   = bank_vec[issue_idx];
  assign issue_row    = row_vec[issue_idx];
  assign issue_thread = thread_vec[issue_idx];

  // R3
  sel_occupied_chk: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> valid_vec[issue_idx]);

  // R3
  empty_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !(|valid_vec) |-> !issue_valid);

  // R5
  hit_first_chk: assert property (@(posedge clk) disable iff (rst)
    (pol == POL_ROWHIT && (|hit_vec)) |-> hit_vec[issue_idx]);
endmodule

// File: tb/req_sched_bench.sv
module req_sched_bench;
  localparam int DEPTH = 8;
  localparam int LIMIT = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  policy = 2'd0;
  logic        push_valid = 1'b0;
  logic [1:0]  push_bank = '0;
  logic [11:0] push_row = '0;
  logic [1:0]  push_thread = '0;
  logic        push_ready;
  logic        issue_valid;
  logic [2:0]  issue_idx;
  logic [1:0]  issue_bank;
  logic [11:0] issue_row;
  logic [1:0]  issue_thread;
  logic        issue_ack = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  req_sched #(.DEPTH(DEPTH), .STARVE_LIMIT(LIMIT)) u_req_sched (
    .clk(clk), .rst(rst), .policy(policy),
    .push_valid(push_valid), .push_bank(push_bank), .push_row(push_row),
    .push_thread(push_thread), .push_ready(push_ready),
    .issue_valid(issue_valid), .issue_idx(issue_idx), .issue_bank(issue_bank),
    .issue_row(issue_row), .issue_thread(issue_thread), .issue_ack(issue_ack)
  );

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_eq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic expect_sel(string req, int idx, int row);
    #1;
    expect_eq(req, "issue_valid", int'(issue_valid), 1);
    expect_eq(req, "issue_idx", int'(issue_idx), idx);
    expect_eq(req, "issue_row", int'(issue_row), row);
  endtask

  task automatic expect_idle(string req);
    #1;
    expect_eq(req, "issue_valid", int'(issue_valid), 0);
  endtask

  task automatic push(int b, int r, int t);
    push_valid  = 1'b1;
    push_bank   = 2'(b);
    push_row    = 12'(r);
    push_thread = 2'(t);
    cyc();
    push_valid  = 1'b0;
  endtask

  task automatic ack();
    issue_ack = 1'b1;
    cyc();
    issue_ack = 1'b0;
  endtask

  // R1: empty after reset, banks closed (row 0 must not hit)
  task automatic t_reset();
    #1;
    expect_eq("R1", "issue_valid", int'(issue_valid), 0);
    expect_eq("R1", "push_ready", int'(push_ready), 1);
    policy = 2'd1;
    push(1, 7, 0);
    push(0, 0, 1);
    expect_sel("R1", 0, 7);
    expect_eq("R3", "issue_bank", int'(issue_bank), 1);
    ack();
    expect_sel("R1", 1, 0);
    expect_eq("R3", "issue_thread", int'(issue_thread), 1);
    ack();
    expect_idle("R3");
  endtask

  // R4: arrival order ignores hits; R9: policy switch seen at once
  task automatic t_fcfs();
    policy = 2'd0;
    push(0, 5, 0);
    push(1, 3, 1);
    push(0, 5, 2);
    expect_sel("R4", 0, 5);
    ack();
    expect_sel("R4", 1, 3);
    policy = 2'd1;
    expect_sel("R9", 2, 5);
    policy = 2'd3;
    expect_sel("R4", 1, 3);
    policy = 2'd0;
    ack();
    expect_sel("R4", 2, 5);
    ack();
    expect_idle("R4");
  endtask

  // R5: hits first, then oldest; R8 row table follows issues
  task automatic t_rowhit();
    push(0, 9, 0);
    push(1, 3, 1);
    push(0, 5, 2);
    policy = 2'd0;
    expect_sel("R4", 0, 9);
    policy = 2'd1;
    expect_sel("R5", 1, 3);
    ack();
    expect_sel("R5", 2, 5);
    ack();
    expect_sel("R5", 0, 9);
    ack();
    expect_idle("R5");
  endtask

  // R6/R7: starvation threshold reached exactly at LIMIT cycles of wait
  task automatic t_fair();
    policy = 2'd2;
    push(2, 1, 3);
    push(0, 9, 1);
    repeat (LIMIT - 2) cyc();
    expect_sel("R6", 1, 9);
    cyc();
    expect_sel("R7", 0, 1);
    policy = 2'd1;
    expect_sel("R6", 1, 9);
    policy = 2'd2;
    ack();
    expect_sel("R6", 1, 9);
    ack();
    expect_idle("R6");
  endtask

  // R8: push and acknowledged issue at the same edge
  task automatic t_overlap();
    policy = 2'd0;
    push(3, 2, 0);
    push(3, 4, 1);
    push(3, 6, 2);
    expect_sel("R8", 0, 2);
    issue_ack   = 1'b1;
    push_valid  = 1'b1;
    push_bank   = 2'd2;
    push_row    = 12'd11;
    push_thread = 2'd3;
    cyc();
    issue_ack   = 1'b0;
    push_valid  = 1'b0;
    expect_sel("R8", 1, 4);
    ack();
    expect_sel("R8", 2, 6);
    ack();
    expect_sel("R8", 3, 11);
    expect_eq("R8", "issue_bank", int'(issue_bank), 2);
    ack();
    expect_idle("R8");
  endtask

  // R2: fill, drop a push while full, drain in order
  task automatic t_full();
    policy = 2'd0;
    for (int i = 0; i < DEPTH; i++) push(i % 4, 100 + i, i % 4);
    #1;
    expect_eq("R2", "push_ready", int'(push_ready), 0);
    push(1, 555, 0);
    for (int i = 0; i < DEPTH; i++) begin
      expect_sel("R2", i, 100 + i);
      ack();
    end
    expect_idle("R2");
    expect_eq("R2", "push_ready", int'(push_ready), 1);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    t_reset();
    t_fcfs();
    t_rowhit();
    t_fair();
    t_overlap();
    t_full();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule